// File: doc/BRIEF.md
# Buffered I2S Serial Audio Port

This block is a stereo I2S master that a processor drives through a byte-wide register bus. It splits the system clock down to a fixed-ratio serial clock and sends 16-bit stereo samples on a serial data output. At the same time it shifts samples in from a serial data input. Each direction has a single holding word. Software services that word through a low data byte register and a high data byte register, and a status register tells it which channel the transmit word must carry and which channel the received word belongs to.

Software can poll the status register for work or wire the two interrupt flags to an interrupt line. Each interrupt flag clears itself when software touches the high data byte. The underflow and overflow error flags stay set until software writes them to 0. A free-running 10-bit count of completed serial words is frozen into a snapshot register on each pulse of a trigger input. Software then reads the snapshot from the status register and a count register.

Top module: `i2s_port`

## Requirements
- R1: While reset is held, the status register reads 0x00, the serial clock output is high and the word-select output is low.
- R2: The word-select output is low for left-channel words and high for right-channel words. It changes only on a falling serial-clock edge, one serial clock before the MSB of the next word. Words are sent MSB first, one bit per falling edge, and are taken in from the data input on rising edges.
- R3: The register addresses are: 0 for the data low byte, 1 for the data high byte, 2 for status, and 3 for the count low byte. A write to address 0 only stages the byte. A write to address 1 commits {high, staged low} as the transmit word and clears the TX interrupt flag (status bit 3). The flag is set each time the serializer takes a word from the buffer.
- R4: Status bit 5 is read-only. It reads 0 when the next word software must load is for the left channel and 1 when it is for the right channel.
- R5: Status bit 7 (TX underflow) is set when the serializer needs a word and the buffer is empty, in which case zeros are sent. It stays set until a status write puts 0 in it.
- R6: Status bit 2 (RX interrupt) is set when a received word enters the receive buffer. A read of address 1 returns the word's high byte, clears the flag and captures the low byte, which later reads of address 0 return.
- R7: Status bit 4 is read-only. It reads 0 when the receive buffer holds a left-channel word and 1 when it holds a right-channel word.
- R8: Status bit 6 (RX overflow) is set when a word arrives while the previous received word has not been read through address 1. It stays set until a status write puts 0 in it.
- R9: A 10-bit counter counts completed serial words and wraps from 1023 to 0. A high pulse on the trigger input latches it. The snapshot's bits 9:8 appear in status bits 1:0 and its bits 7:0 at address 3.
- R10: A status write loads bits 7, 6, 3 and 2 from the write data (1 sets a flag, 0 clears it) and leaves bits 5, 4, 1 and 0 unchanged. A hardware set in the same cycle wins over a software clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 1) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| snap_trig | input | 1 | Word-count snapshot trigger |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 left, 1 right) |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The assertions assume that the read and write strobes are never high together and that each access lasts exactly one clock. The bench's bus tasks drive one strobe for one cycle at a time. The flag assertions also assume that software never clears a flag in the same cycle the hardware sets it. The bench avoids this by doing its status writes just after a serial word boundary, when no hardware event is due for many clocks. The serial data input is looped back from the output, so every received word equals a word the bench wrote earlier or zero.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
   typedef enum logic [1:0] {
      RA_DLO  = 2'd0,
      RA_DHI  = 2'd1,
      RA_STAT = 2'd2,
      RA_CNT  = 2'd3
   } reg_addr_e;

   localparam int ST_TXUNF = 7;
   localparam int ST_RXOVF = 6;
   localparam int ST_TXCH  = 5;
   localparam int ST_RXCH  = 4;
   localparam int ST_TXIRQ = 3;
   localparam int ST_RXIRQ = 2;
endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic sck,
   output logic fall_evt,
   output logic rise_evt
);
   logic tog;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_fast
      assign tog = 1'b1;
   end else begin : g_cnt
      localparam int DW = $clog2(HALF_DIV);
      localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)           cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
      assign tog = (cnt == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   sck <= 1'b1;
      else if (tog) sck <= ~sck;
   end

   assign fall_evt = tog & sck;
   assign rise_evt = tog & ~sck;
endmodule

// File: rtl/i2s_serdes.sv
module i2s_serdes #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_evt,
   input  logic              rise_evt,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              sd_i,
   output logic              ws,
   output logic              sd_o,
   output logic              load_evt,
   output logic              load_ch,
   output logic              rx_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_ch,
   output logic [CNT_W-1:0]  wcnt
);
   localparam int BW = $clog2(WORD_W);
   localparam int PW = BW + 1;

   if ((1 << BW) != WORD_W) begin : g_bad_w
      $error("WORD_W must be a power of two");
   end

   logic [PW-1:0]     pos, pos_nx;
   logic [WORD_W-1:0] tsh, rsh;

   assign pos_nx   = pos + 1'b1;
   assign ws       = pos_nx[PW-1];
   assign sd_o     = tsh[WORD_W-1];
   assign load_evt = fall_evt && (pos_nx[BW-1:0] == '0);
   assign load_ch  = pos_nx[PW-1];
   assign rx_done  = rise_evt && (pos[BW-1:0] == '1);
   assign rx_word  = {rsh[WORD_W-2:0], sd_i};
   assign rx_ch    = pos[PW-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '1;
         tsh <= '0;
      end else if (fall_evt) begin
         pos <= pos_nx;
         if (pos_nx[BW-1:0] == '0) tsh <= tx_word;
         else                      tsh <= {tsh[WORD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rsh <= '0;
      else if (rise_evt) rsh <= rx_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       wcnt <= '0;
      else if (rx_done) wcnt <= wcnt + 1'b1;
   end

   a_r2_ws_on_fall : assert property (@(posedge clk) disable iff (!rst_n)
      !fall_evt |=> $stable(ws));
   a_r9_cnt_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |=> $stable(wcnt));
endmodule

// File: rtl/i2s_regs.sv
module i2s_regs
   import i2s_port_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              load_evt,
   input  logic              load_ch,
   input  logic              rx_done,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_ch,
   input  logic [CNT_W-1:0]  wcnt,
   input  logic              trig,
   output logic [WORD_W-1:0] tx_word
);
   if (WORD_W != 16) begin : g_bad_w
      $error("byte-pair data registers need WORD_W of 16");
   end
   if (CNT_W != 10) begin : g_bad_cnt
      $error("status/count split needs CNT_W of 10");
   end

   logic              wr_lo, wr_hi, wr_st, rd_hi;
   logic [7:0]        tx_stage, rx_lo_hold;
   logic [WORD_W-1:0] tx_buf, rx_buf;
   logic              tx_full, rx_full, tx_ch_need, rx_ch_hold;
   logic              tx_irq, rx_irq, tx_unf, rx_ovf;
   logic [CNT_W-1:0]  snap;

   assign wr_lo = wr && (addr == RA_DLO);
   assign wr_hi = wr && (addr == RA_DHI);
   assign wr_st = wr && (addr == RA_STAT);
   assign rd_hi = rd && (addr == RA_DHI);

   assign tx_word = tx_full ? tx_buf : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_stage   <= '0;
         tx_buf     <= '0;
         tx_full    <= 1'b0;
         tx_ch_need <= 1'b0;
      end else begin
         if (wr_lo) tx_stage <= wdata;
         if (wr_hi) tx_buf <= {wdata, tx_stage};
         if (wr_hi)         tx_full <= 1'b1;
         else if (load_evt) tx_full <= 1'b0;
         if (load_evt) tx_ch_need <= ~load_ch;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_buf     <= '0;
         rx_full    <= 1'b0;
         rx_ch_hold <= 1'b0;
         rx_lo_hold <= '0;
      end else begin
         if (rx_done) begin
            rx_buf     <= rx_word;
            rx_full    <= 1'b1;
            rx_ch_hold <= rx_ch;
         end else if (rd_hi) begin
            rx_full <= 1'b0;
         end
         if (rd_hi) rx_lo_hold <= rx_buf[7:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
         rx_irq <= 1'b0;
         tx_unf <= 1'b0;
         rx_ovf <= 1'b0;
      end else begin
         if (load_evt)   tx_irq <= 1'b1;
         else if (wr_hi) tx_irq <= 1'b0;
         else if (wr_st) tx_irq <= wdata[ST_TXIRQ];

         if (rx_done)    rx_irq <= 1'b1;
         else if (rd_hi) rx_irq <= 1'b0;
         else if (wr_st) rx_irq <= wdata[ST_RXIRQ];

         if (load_evt && !tx_full) tx_unf <= 1'b1;
         else if (wr_st)           tx_unf <= wdata[ST_TXUNF];

         if (rx_done && rx_full) rx_ovf <= 1'b1;
         else if (wr_st)         rx_ovf <= wdata[ST_RXOVF];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    snap <= '0;
      else if (trig) snap <= wcnt;
   end

   always_comb begin
      unique case (addr)
         RA_DLO:  rdata = rx_lo_hold;
         RA_DHI:  rdata = rx_buf[15:8];
         RA_STAT: rdata = {tx_unf, rx_ovf, tx_ch_need, rx_ch_hold,
                           tx_irq, rx_irq, snap[9:8]};
         default: rdata = snap[7:0];
      endcase
   end

   a_r3_txirq_on_load : assert property (@(posedge clk) disable iff (!rst_n)
      load_evt |=> tx_irq);
   a_r6_rxirq_on_word : assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rx_irq);
   a_r6_rxirq_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !rx_done) |=> !rx_irq);
   a_r8_ovf_on_unread : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full) |=> rx_ovf);
   a_r5_unf_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_unf && !wr_st) |=> tx_unf);
   a_r10_one_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && rd));
endmodule

// File: rtl/i2s_port.sv
module i2s_port #(
   parameter int HALF_DIV = 4,
   parameter int WORD_W   = 16,
   parameter int CNT_W    = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       snap_trig,
   output logic       sck_o,
   output logic       ws_o,
   output logic       sd_o,
   input  logic       sd_i
);
   logic              fall_evt, rise_evt, load_evt, load_ch, rx_done, rx_ch;
   logic [WORD_W-1:0] tx_word, rx_word;
   logic [CNT_W-1:0]  wcnt;

   i2s_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
      .clk(clk), .rst_n(rst_n), .sck(sck_o),
      .fall_evt(fall_evt), .rise_evt(rise_evt)
   );

   i2s_serdes #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_serdes (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .rise_evt(rise_evt),
      .tx_word(tx_word), .sd_i(sd_i), .ws(ws_o), .sd_o(sd_o),
      .load_evt(load_evt), .load_ch(load_ch), .rx_done(rx_done),
      .rx_word(rx_word), .rx_ch(rx_ch), .wcnt(wcnt)
   );

   i2s_regs #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .rdata(reg_rdata), .load_evt(load_evt),
      .load_ch(load_ch), .rx_done(rx_done), .rx_word(rx_word), .rx_ch(rx_ch),
      .wcnt(wcnt), .trig(snap_trig), .tx_word(tx_word)
   );
endmodule

// File: tb/sim_i2s_port.sv
module sim_i2s_port;
   localparam int CLK_P = 10;
   localparam int NRX   = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       snap_trig = 1'b0;
   logic       sck, ws, sdo;

   int n_chk = 0, n_fail = 0;
   int words = 0, ktx = 0, ridx = 0;
   logic [15:0] exp_tx [0:63];
   logic [15:0] dec = '0;
   logic m_ws = 1'b0, m_sck = 1'b1, last_ws = 1'b0;

   i2s_port #(.HALF_DIV(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .snap_trig(snap_trig), .sck_o(sck), .ws_o(ws), .sd_o(sdo), .sd_i(sdo)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [15:0] wv(input int k);
      return 16'(k * 16'h1357) ^ 16'h8C3A;
   endfunction

   // serial-side observer: framing, decoded words, completed-word count
   always @(negedge clk) begin
      if (rst_n) begin
         if (ws !== m_ws)
            check("R2 ws changes only on sck fall", int'(m_sck && !sck), 1);
         if (!m_sck && sck) begin
            dec = {dec[14:0], sdo};
            if (ws != last_ws) begin
               words++;
               if (words - 1 <= ktx && words - 1 < 64) begin
                  check("R2 serial word", int'(dec), int'(exp_tx[words-1]));
                  check("R2 serial channel", int'(last_ws), (words - 1) % 2);
               end
               last_ws = ws;
            end
         end
         m_ws = ws; m_sck = sck;
      end
   end

   task automatic wait_words(input int n);
      int target = words + n;
      while (words < target) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic snap_check(input string tag);
      logic [7:0] lo, st;
      @(negedge clk); snap_trig = 1'b1;
      @(negedge clk); snap_trig = 1'b0;
      bus_rd(2'd3, lo);
      bus_rd(2'd2, st);
      check({tag, " count low"}, int'(lo), words % 256);
      check({tag, " count high"}, int'(st[1:0]), (words / 256) % 4);
   endtask

   initial begin
      logic [7:0] s, s0, hi, lo;
      exp_tx[0] = 16'h0000;
      repeat (3) @(negedge clk);
      reg_addr = 2'd2;
      #1;
      check("R1 status at reset", int'(reg_rdata), 0);
      check("R1 sck at reset", int'(sck), 1);
      check("R1 ws at reset", int'(ws), 0);
      rst_n = 1'b1;

      // service loop: fill every transmit slot, drain every received word
      while (ridx < NRX) begin
         bus_rd(2'd2, s);
         if (s[3]) begin
            if (ktx == 0) check("R5 underflow at start", int'(s[7]), 1);
            ktx++;
            check("R4 tx channel", int'(s[5]), ktx % 2);
            exp_tx[ktx] = wv(ktx);
            bus_wr(2'd0, wv(ktx)[7:0]);
            bus_wr(2'd1, wv(ktx)[15:8]);
            bus_rd(2'd2, s0);
            check("R3 tx irq cleared by high write", int'(s0[3]), 0);
         end
         if (s[2]) begin
            check("R7 rx channel", int'(s[4]), ridx % 2);
            bus_rd(2'd1, hi);
            bus_rd(2'd0, lo);
            check("R6 rx word", int'({hi, lo}), int'(exp_tx[ridx]));
            bus_rd(2'd2, s0);
            check("R6 rx irq cleared by high read", int'(s0[2]), 0);
            ridx++;
         end
      end

      // R5 clear, R10 direct flag writes
      s = 8'h00;
      while (!s[3]) bus_rd(2'd2, s);
      bus_wr(2'd2, 8'h00);
      bus_rd(2'd2, s0);
      check("R5 underflow cleared", int'(s0[7]), 0);
      check("R10 tx irq cleared by write", int'(s0[3]), 0);
      bus_wr(2'd2, 8'h3C);
      bus_rd(2'd2, s);
      check("R10 tx irq set by write", int'(s[3]), 1);
      check("R10 rx irq set by write", int'(s[2]), 1);
      check("R10 read-only bits kept", int'(s[5:4]), int'(s0[5:4]));
      check("R10 error bits written 0", int'(s[7:6]), 0);
      bus_wr(2'd2, 8'h00);

      // R8 overflow: let two words arrive unread
      check("R8 no overflow yet", int'(s[6]), 0);
      wait_words(2);
      bus_rd(2'd2, s);
      check("R8 overflow set", int'(s[6]), 1);
      wait_words(1);
      bus_rd(2'd2, s);
      check("R8 overflow sticky", int'(s[6]), 1);
      bus_wr(2'd2, 8'h00);
      bus_rd(2'd2, s);
      check("R8 overflow cleared", int'(s[6]), 0);

      // R9 snapshot, then past the wrap
      snap_check("R9 early");
      wait_words(1);
      snap_check("R9 next word");
      while (words < 1030) @(negedge clk);
      wait_words(1);
      snap_check("R9 after wrap");

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule